// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block is the receive half of an asynchronous serial port. Its clock runs at sixteen times the bit rate and is also its sampling tick. The block watches a serial line that rests high. A falling edge on the line opens a start-bit check. It then collects a character of five to eight data bits, least significant bit first. An optional parity bit and a stop bit follow. Each finished character is copied into a parallel holding register, aligned to bit 0.

The host sees a data-received flag, which it clears by pulling an active-low clear input low. Three error flags travel with each character: overrun (the host had not cleared the flag before the next character landed), framing (the stop bit sampled low) and parity. The character lands in the holding register in the middle of the first stop bit. The data-received flag and the framing result follow on the next clock. Word length, parity enable and parity sense are static inputs that the host holds constant while a character is in flight. Only the first stop bit is checked. A second stop bit therefore looks like idle line.

Top module: `serial_rx_unit`

## Requirements
- R1: After reset, `rx_data_o` is zero and `rx_valid_o`, `ovr_err_o`, `frm_err_o` and `par_err_o` are all low.
- R2: A character begins only on a high-to-low change of the line. The line is sampled again 8 ticks later. If it is high by then, the start is false: no character is stored and no output changes.
- R3: Each data bit is sampled once, 16 ticks after the previous sample, least significant bit first. `cfg_wlen_i` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. The character is aligned to bit 0 of `rx_data_o`, and the unused high bits read zero.
- R4: When `cfg_par_en_i` is 1, one parity bit follows the last data bit. With `cfg_par_odd_i` = 1 the count of ones over the data and parity bits must be odd; with 0 it must be even. A mismatch sets `par_err_o` with the character. When parity is off, no parity bit is expected and `par_err_o` is 0.
- R5: `frm_err_o` is 1 for a character whose stop bit sampled low and 0 for one whose stop bit sampled high.
- R6: The character is written to `rx_data_o` during the first stop bit. Exactly one clock after `rx_data_o` is written, `rx_valid_o` goes high and `frm_err_o` takes the new value.
- R7: While `dr_clr_ni` is low, `rx_valid_o` is cleared at the next clock edge, unless that same edge is the one that sets it.
- R8: On each transfer, `ovr_err_o` is set if `rx_valid_o` was still high in the transfer cycle and is cleared otherwise. Between transfers, `ovr_err_o`, `par_err_o` and `rx_data_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock at 16 times the bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, high when idle |
| cfg_wlen_i | input | 2 | Data bits: 0 gives 5, up to 3 giving 8 |
| cfg_par_en_i | input | 1 | 1 expects a parity bit |
| cfg_par_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| dr_clr_ni | input | 1 | Low clears the data-received flag |
| rx_data_o | output | MAX_BITS | Last received character, aligned to bit 0 |
| rx_valid_o | output | 1 | Data-received flag |
| ovr_err_o | output | 1 | Overrun error |
| frm_err_o | output | 1 | Framing error |
| par_err_o | output | 1 | Parity error |

## Verification
A bit counter or tick counter that drifts shows up at the ports within one character. The character appears shifted or with stray high bits. A parity or stop sample then falls on the wrong bit and raises a false error flag. A state machine that fails to leave start detection after a glitch shows up as a phantom character, or as a real character that is misaligned on the next frame. Wrong sequencing in the status register shows up within two clocks of the transfer: either `rx_valid_o` rises in the same cycle as the data, or an overrun is reported after the host has already cleared the flag.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int WLEN_W = 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP
    } rx_phase_e;

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic din_i,
    output logic dout_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], din_i};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= chain_d;
    end

    assign dout_o = chain_q[STAGES-1];
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
    import serial_rx_pkg::*;
#(
    parameter int MAX_BITS = 8,
    parameter int OVS      = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                rx_s_i,
    input  logic [WLEN_W-1:0]   cfg_wlen_i,
    input  logic                cfg_par_en_i,
    input  logic                cfg_par_odd_i,
    output logic                xfer_o,
    output logic [MAX_BITS-1:0] data_o,
    output logic                par_bad_o,
    output logic                stop_o
);
    localparam int CNT_W    = $clog2(OVS);
    localparam int IDX_W    = $clog2(MAX_BITS);
    localparam int MIN_BITS = MAX_BITS - 3;
    localparam logic [CNT_W-1:0] MID_TICK  = CNT_W'(OVS/2 - 1);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OVS - 1);

    typedef struct packed {
        rx_phase_e           phase;
        logic [CNT_W-1:0]    cnt;
        logic [IDX_W-1:0]    bit_idx;
        logic [MAX_BITS-1:0] shreg;
        logic                par_acc;
        logic                par_bad;
        logic                rx_prev;
    } frame_t;

    frame_t d, q;
    logic [IDX_W:0] nbits, shamt;
    logic           xfer;

    always_comb begin
        nbits = MIN_BITS[IDX_W:0] + {{(IDX_W-1){1'b0}}, cfg_wlen_i};
        shamt = MAX_BITS[IDX_W:0] - nbits;
    end

    always_comb begin
        d         = q;
        xfer      = 1'b0;
        d.rx_prev = rx_s_i;
        unique case (q.phase)
            PH_IDLE: begin
                if (q.rx_prev && !rx_s_i) begin
                    d.phase   = PH_START;
                    d.cnt     = '0;
                    d.bit_idx = '0;
                    d.shreg   = '0;
                    d.par_acc = 1'b0;
                    d.par_bad = 1'b0;
                end
            end
            PH_START: begin
                if (q.cnt == MID_TICK) begin
                    d.cnt   = '0;
                    d.phase = rx_s_i ? PH_IDLE : PH_DATA;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            PH_DATA: begin
                if (q.cnt == LAST_TICK) begin
                    d.cnt     = '0;
                    d.shreg   = {rx_s_i, q.shreg[MAX_BITS-1:1]};
                    d.par_acc = q.par_acc ^ rx_s_i;
                    d.bit_idx = q.bit_idx + 1'b1;
                    if ({1'b0, q.bit_idx} == nbits - 1'b1)
                        d.phase = cfg_par_en_i ? PH_PARITY : PH_STOP;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            PH_PARITY: begin
                if (q.cnt == LAST_TICK) begin
                    d.cnt     = '0;
                    d.par_bad = ((q.par_acc ^ rx_s_i) != cfg_par_odd_i);
                    d.phase   = PH_STOP;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            PH_STOP: begin
                if (q.cnt == LAST_TICK) begin
                    d.cnt   = '0;
                    xfer    = 1'b1;
                    d.phase = PH_IDLE;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q         <= '0;
            q.phase   <= PH_IDLE;
            q.rx_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign xfer_o    = xfer;
    assign data_o    = q.shreg >> shamt;
    assign par_bad_o = q.par_bad;
    assign stop_o    = rx_s_i;
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status #(
    parameter int MAX_BITS = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                xfer_i,
    input  logic [MAX_BITS-1:0] data_i,
    input  logic                par_bad_i,
    input  logic                stop_i,
    input  logic                clr_ni,
    output logic [MAX_BITS-1:0] data_o,
    output logic                valid_o,
    output logic                ovr_o,
    output logic                frm_o,
    output logic                par_o
);
    typedef struct packed {
        logic [MAX_BITS-1:0] data;
        logic                valid;
        logic                ovr;
        logic                frm;
        logic                par;
        logic                fin;
        logic                stop;
    } stat_t;

    stat_t d, q;

    always_comb begin
        d     = q;
        d.fin = xfer_i;
        if (xfer_i) begin
            d.data = data_i;
            d.ovr  = q.valid;
            d.par  = par_bad_i;
            d.stop = stop_i;
        end
        if (q.fin) begin
            d.valid = 1'b1;
            d.frm   = !q.stop;
        end else if (!clr_ni) begin
            d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign data_o  = q.data;
    assign valid_o = q.valid;
    assign ovr_o   = q.ovr;
    assign frm_o   = q.frm;
    assign par_o   = q.par;
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
    import serial_rx_pkg::*;
#(
    parameter int MAX_BITS    = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                rx_i,
    input  logic [1:0]          cfg_wlen_i,
    input  logic                cfg_par_en_i,
    input  logic                cfg_par_odd_i,
    input  logic                dr_clr_ni,
    output logic [MAX_BITS-1:0] rx_data_o,
    output logic                rx_valid_o,
    output logic                ovr_err_o,
    output logic                frm_err_o,
    output logic                par_err_o
);
    logic                rx_s;
    logic                xfer;
    logic [MAX_BITS-1:0] xfer_data;
    logic                xfer_par_bad;
    logic                xfer_stop;

    serial_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .din_i  (rx_i),
        .dout_o (rx_s)
    );

    serial_rx_frame #(.MAX_BITS(MAX_BITS), .OVS(OVS)) i_frame (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .rx_s_i        (rx_s),
        .cfg_wlen_i    (cfg_wlen_i),
        .cfg_par_en_i  (cfg_par_en_i),
        .cfg_par_odd_i (cfg_par_odd_i),
        .xfer_o        (xfer),
        .data_o        (xfer_data),
        .par_bad_o     (xfer_par_bad),
        .stop_o        (xfer_stop)
    );

    serial_rx_status #(.MAX_BITS(MAX_BITS)) i_status (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .xfer_i    (xfer),
        .data_i    (xfer_data),
        .par_bad_i (xfer_par_bad),
        .stop_i    (xfer_stop),
        .clr_ni    (dr_clr_ni),
        .data_o    (rx_data_o),
        .valid_o   (rx_valid_o),
        .ovr_o     (ovr_err_o),
        .frm_o     (frm_err_o),
        .par_o     (par_err_o)
    );
endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker #(
    parameter int MAX_BITS = 8
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic [1:0]          cfg_wlen_i,
    input logic                dr_clr_ni,
    input logic                xfer_i,
    input logic [MAX_BITS-1:0] rx_data_o,
    input logic                rx_valid_o,
    input logic                ovr_err_o,
    input logic                frm_err_o,
    input logic                par_err_o
);
    a_r6_valid_after_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
        xfer_i |=> ##1 rx_valid_o);

    a_r6_frm_only_after_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(xfer_i) |=> $stable(frm_err_o));

    a_r7_clear_drops_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!dr_clr_ni && !$past(xfer_i)) |=> !rx_valid_o);

    a_r8_overrun_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (xfer_i && rx_valid_o) |=> ovr_err_o);

    a_r8_overrun_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (xfer_i && !rx_valid_o) |=> !ovr_err_o);

    a_r8_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !xfer_i |=> ($stable(ovr_err_o) && $stable(par_err_o) && $stable(rx_data_o)));

    a_r3_short_word_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (xfer_i && cfg_wlen_i == 2'd0) |=> (rx_data_o[MAX_BITS-1:MAX_BITS-3] == 3'b000));
endmodule

bind serial_rx_unit serial_rx_checker #(.MAX_BITS(MAX_BITS)) i_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_wlen_i (cfg_wlen_i),
    .dr_clr_ni  (dr_clr_ni),
    .xfer_i     (xfer),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o),
    .ovr_err_o  (ovr_err_o),
    .frm_err_o  (frm_err_o),
    .par_err_o  (par_err_o)
);

// File: tb/test_serial_rx_unit.sv
module test_serial_rx_unit;
    localparam int OVS = 16;

    typedef struct packed {
        logic [1:0] wlen;
        logic       pen;
        logic       podd;
        logic [7:0] data;
        logic       bad_par;
        logic       bad_stop;
        logic [7:0] exp_data;
        logic       exp_pe;
        logic       exp_fe;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{2'd3, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0},
        '{2'd0, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 8'h1F, 1'b0, 1'b0},
        '{2'd1, 1'b1, 1'b0, 8'h3C, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0},
        '{2'd2, 1'b1, 1'b1, 8'hD5, 1'b0, 1'b0, 8'h55, 1'b0, 1'b0},
        '{2'd3, 1'b1, 1'b0, 8'h81, 1'b1, 1'b0, 8'h81, 1'b1, 1'b0},
        '{2'd3, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b1, 8'h5A, 1'b0, 1'b1},
        '{2'd0, 1'b1, 1'b1, 8'h0A, 1'b1, 1'b0, 8'h0A, 1'b1, 1'b0},
        '{2'd3, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic [1:0] wlen = 2'd3;
    logic       pen = 1'b0;
    logic       podd = 1'b0;
    logic       clr_n = 1'b1;
    logic [7:0] rdata;
    logic       rvalid, oerr, ferr, perr;
    int         n_chk = 0;
    int         n_bad = 0;

    always #4 clk = ~clk;

    serial_rx_unit i_serial_rx_unit (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .rx_i          (rx),
        .cfg_wlen_i    (wlen),
        .cfg_par_en_i  (pen),
        .cfg_par_odd_i (podd),
        .dr_clr_ni     (clr_n),
        .rx_data_o     (rdata),
        .rx_valid_o    (rvalid),
        .ovr_err_o     (oerr),
        .frm_err_o     (ferr),
        .par_err_o     (perr)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic hold_bit(input logic v);
        rx = v;
        repeat (OVS) @(negedge clk);
    endtask

    task automatic send_frame(input logic [1:0] wl, input logic pe_on, input logic odd,
                              input logic [7:0] dat, input logic flip_par, input logic low_stop);
        int   n;
        logic p;
        n = 5 + int'(wl);
        p = 1'b0;
        hold_bit(1'b0);
        for (int i = 0; i < n; i++) begin
            p = p ^ dat[i];
            hold_bit(dat[i]);
        end
        if (pe_on) hold_bit(p ^ odd ^ flip_par);
        hold_bit(!low_stop);
        hold_bit(1'b1);
        hold_bit(1'b1);
    endtask

    task automatic clear_flag();
        clr_n = 1'b0;
        @(negedge clk);
        check("R7 valid after clear", {7'b0, rvalid}, 8'h00);
        clr_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 data after reset", rdata, 8'h00);
        check("R1 flags after reset", {4'b0, rvalid, oerr, ferr, perr}, 8'h00);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        for (int k = 0; k < NVEC; k++) begin
            wlen = VECS[k].wlen;
            pen  = VECS[k].pen;
            podd = VECS[k].podd;
            send_frame(VECS[k].wlen, VECS[k].pen, VECS[k].podd, VECS[k].data,
                       VECS[k].bad_par, VECS[k].bad_stop);
            check("R6 valid set", {7'b0, rvalid}, 8'h01);
            check("R3 data", rdata, VECS[k].exp_data);
            check("R4 parity flag", {7'b0, perr}, {7'b0, VECS[k].exp_pe});
            check("R5 framing flag", {7'b0, ferr}, {7'b0, VECS[k].exp_fe});
            check("R8 no overrun", {7'b0, oerr}, 8'h00);
            clear_flag();
        end

        // R6: data lands one clock before the flag
        wlen = 2'd3; pen = 1'b0; podd = 1'b0;
        fork
            send_frame(2'd3, 1'b0, 1'b0, 8'h96, 1'b0, 1'b0);
            begin : watch
                int  w;
                w = 0;
                while (rdata == 8'h00 && w < 400) begin
                    @(negedge clk);
                    w++;
                end
                check("R6 data changed", rdata, 8'h96);
                check("R6 valid low with new data", {7'b0, rvalid}, 8'h00);
                @(negedge clk);
                check("R6 valid one clock later", {7'b0, rvalid}, 8'h01);
                check("R6 framing one clock later", {7'b0, ferr}, 8'h00);
            end
        join

        // R8: overrun sequence, flag left set
        send_frame(2'd3, 1'b0, 1'b0, 8'h11, 1'b0, 1'b0);
        check("R8 data under overrun", rdata, 8'h11);
        check("R8 overrun set", {7'b0, oerr}, 8'h01);
        send_frame(2'd3, 1'b0, 1'b0, 8'h22, 1'b0, 1'b0);
        check("R8 overrun still set", {7'b0, oerr}, 8'h01);
        clear_flag();
        check("R8 overrun holds after clear", {7'b0, oerr}, 8'h01);
        send_frame(2'd3, 1'b0, 1'b0, 8'h33, 1'b0, 1'b0);
        check("R8 overrun cleared by next char", {7'b0, oerr}, 8'h00);
        check("R8 data after overrun", rdata, 8'h33);
        clear_flag();

        // R2: short low glitch is a false start
        rx = 1'b0;
        repeat (4) @(negedge clk);
        rx = 1'b1;
        repeat (64) @(negedge clk);
        check("R2 no character from glitch", {7'b0, rvalid}, 8'h00);
        check("R2 data untouched by glitch", rdata, 8'h33);
        send_frame(2'd3, 1'b0, 1'b0, 8'h5C, 1'b0, 1'b0);
        check("R2 next character aligned", rdata, 8'h5C);
        check("R2 next character valid", {7'b0, rvalid}, 8'h01);

        summary();
    end
endmodule